// File: doc/BRIEF.md
# Virtual Address Segment Translator

This block turns a 64-bit virtual address into a physical address for a processor core that has no TLB. It can translate only the segments that map straight onto physical memory. Every mapped segment is reported as an address error.

A requester presents a virtual address together with an access kind: instruction fetch, data load or data store. One clock later the block returns a response. The response is either a physical address, or a fault flag with the matching exception code and the faulting virtual address, which an exception unit can record as the bad address.

The block picks the region from the two top address bits. The direct physical window strips its cache-mode bits and keeps the low 59 bits. The kernel region translates only through its 32-bit compatibility view, and only the cached and uncached unmapped segments of that view translate. Everything else faults.

Top module: `vaddr_seg_xlate`

## Requirements
- R1: The response valid `rsp_valid` is high exactly one cycle after a cycle with `req_valid` high, and is low otherwise. While `rsp_valid` is low, `rsp_fault`, `rsp_code`, `rsp_paddr` and `rsp_badaddr` are all zero. A synchronous active-low reset clears all of them.
- R2: If vaddr[63:62] = 2'b10, the access translates without fault. The physical address is vaddr[58:0] zero-extended to 64 bits, so bits 61..59 have no effect on the result.
- R3: If vaddr[63:62] = 2'b11, vaddr[61:31] is all ones and vaddr[30:29] is 2'b00 or 2'b01, the access translates without fault. The physical address is vaddr[28:0] zero-extended.
- R4: If vaddr[63:62] = 2'b11, vaddr[61:31] is all ones and vaddr[30:29] is 2'b10 or 2'b11, the access faults.
- R5: If vaddr[63:62] = 2'b11 and any bit of vaddr[61:31] is zero, the access faults.
- R6: If vaddr[63:62] is 2'b00 or 2'b01, the access faults.
- R7: `req_kind` encodes fetch = 2'b00, load = 2'b01, store = 2'b10; 2'b11 is handled as a load. On a fault, `rsp_code` is 5'h05 for a store and 5'h04 for any other kind. Without a fault, `rsp_code` is 0.
- R8: `rsp_paddr` is zero whenever `rsp_fault` is high.
- R9: On a fault, `rsp_badaddr` equals the virtual address of the request. Without a fault it is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_vaddr | input | 64 | Virtual address |
| req_kind | input | 2 | Access kind: fetch, load or store |
| rsp_valid | output | 1 | Response present |
| rsp_fault | output | 1 | Address error |
| rsp_code | output | 5 | Exception code on a fault |
| rsp_paddr | output | 64 | Physical address, zero on a fault |
| rsp_badaddr | output | 64 | Faulting virtual address |

## Verification
The bench sweeps every region and cache-mode value with every access kind. It also clears each bit of the kernel all-ones field, one at a time, so that a check that looks at only part of vaddr[61:31] lets one of those addresses through when it should fault. It walks all four compatibility segments, so a wrong segment test either faults on the unmapped ones or translates the mapped ones. Store and non-store faults are compared on the same addresses, to catch a swapped or constant error code. The reserved access kind is included, and it must produce the load code.

// File: rtl/xl_pkg.sv
// Shared types and code values for the segment translator.
// Assumes 64-bit virtual addresses with the region in the top two bits.
package xl_pkg;
    typedef enum logic [1:0] {
        ACC_FETCH = 2'b00,
        ACC_LOAD  = 2'b01,
        ACC_STORE = 2'b10,
        ACC_RSVD  = 2'b11
    } acc_kind_t;

    typedef enum logic [1:0] {
        RGN_USER  = 2'b00,
        RGN_SUPV  = 2'b01,
        RGN_PHYS  = 2'b10,
        RGN_KERN  = 2'b11
    } region_t;

    localparam int CODE_W = 5;
    localparam logic [CODE_W-1:0] CODE_LOAD_ERR  = 5'h04;
    localparam logic [CODE_W-1:0] CODE_STORE_ERR = 5'h05;
endpackage

// File: rtl/xl_seg_decode.sv
// Combinational segment decode and physical address formation.
// Assumes ADDR_W is 64: the slice positions follow the fixed segment layout.
module xl_seg_decode
    import xl_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic [ADDR_W-1:0] vaddr,
    output logic              hit,
    output logic [ADDR_W-1:0] paddr
);
    localparam int RGN_HI  = ADDR_W - 1;
    localparam int RGN_LO  = ADDR_W - 2;
    localparam int KTOP_HI = ADDR_W - 3;
    localparam int KTOP_LO = 31;
    localparam int CSEG_HI = 30;
    localparam int WIN_W   = ADDR_W - 5;
    localparam int CPT_W   = 29;

    region_t rgn;
    logic    ktop_ones;

    assign rgn       = region_t'(vaddr[RGN_HI:RGN_LO]);
    assign ktop_ones = &vaddr[KTOP_HI:KTOP_LO];

    // Select the region and build the zero-extended physical address.
    always_comb begin
        hit   = 1'b0;
        paddr = '0;
        case (rgn)
            RGN_PHYS: begin
                hit   = 1'b1;
                paddr = {{(ADDR_W-WIN_W){1'b0}}, vaddr[WIN_W-1:0]};
            end
            RGN_KERN: begin
                // Compatibility segments with bit 30 clear are unmapped.
                if (ktop_ones && !vaddr[CSEG_HI]) begin
                    hit   = 1'b1;
                    paddr = {{(ADDR_W-CPT_W){1'b0}}, vaddr[CPT_W-1:0]};
                end
            end
            default: begin
                hit   = 1'b0;
                paddr = '0;
            end
        endcase
    end
endmodule

// File: rtl/xl_fault_code.sv
// Picks the address-error code from the access kind.
// Assumes the caller qualifies the result with the fault flag.
module xl_fault_code
    import xl_pkg::*;
(
    input  acc_kind_t          kind,
    input  logic               fault,
    output logic [CODE_W-1:0]  code
);
    // Store faults get the store code, all other kinds the load code.
    always_comb begin
        if (!fault)                code = '0;
        else if (kind == ACC_STORE) code = CODE_STORE_ERR;
        else                       code = CODE_LOAD_ERR;
    end
endmodule

// File: rtl/vaddr_seg_xlate.sv
// Top of the segment translator: decode, code select, one response register.
// Assumes one request per cycle at most; the response follows one cycle later.
module vaddr_seg_xlate
    import xl_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic [1:0]        req_kind,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic [CODE_W-1:0] rsp_code,
    output logic [ADDR_W-1:0] rsp_paddr,
    output logic [ADDR_W-1:0] rsp_badaddr
);
    logic              dec_hit;
    logic [ADDR_W-1:0] dec_paddr;
    logic              nxt_fault;
    logic [CODE_W-1:0] nxt_code;

    xl_seg_decode #(.ADDR_W(ADDR_W)) u_dec (
        .vaddr (req_vaddr),
        .hit   (dec_hit),
        .paddr (dec_paddr)
    );

    assign nxt_fault = req_valid && !dec_hit;

    xl_fault_code u_code (
        .kind  (acc_kind_t'(req_kind)),
        .fault (nxt_fault),
        .code  (nxt_code)
    );

    // Register the response; idle cycles leave every field at zero.
    always_ff @(posedge clk) begin
        if (!rst_n || !req_valid) begin
            rsp_valid   <= 1'b0;
            rsp_fault   <= 1'b0;
            rsp_code    <= '0;
            rsp_paddr   <= '0;
            rsp_badaddr <= '0;
        end else begin
            rsp_valid   <= 1'b1;
            rsp_fault   <= nxt_fault;
            rsp_code    <= nxt_code;
            rsp_paddr   <= nxt_fault ? '0 : dec_paddr;
            rsp_badaddr <= nxt_fault ? req_vaddr : '0;
        end
    end

    AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> rsp_valid == $past(req_valid)); // R1
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_fault && rsp_paddr == '0 && rsp_badaddr == '0)); // R1
    AST_PHYS_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(req_valid) && $past(req_vaddr[ADDR_W-1:ADDR_W-2]) == 2'b10)
        |-> !rsp_fault); // R2
    AST_USER_SUPV_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(req_valid) && !$past(req_vaddr[ADDR_W-1]))
        |-> rsp_fault); // R6
    AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_code == CODE_LOAD_ERR || rsp_code == CODE_STORE_ERR)); // R7
    AST_FAULT_PADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> rsp_paddr == '0); // R8
    AST_BADADDR_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && rsp_fault) |-> rsp_badaddr == $past(req_vaddr)); // R9
endmodule

// File: tb/vaddr_seg_xlate_test.sv
module vaddr_seg_xlate_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [63:0] req_vaddr = '0;
    logic [1:0]  req_kind = '0;
    logic        rsp_valid;
    logic        rsp_fault;
    logic [4:0]  rsp_code;
    logic [63:0] rsp_paddr;
    logic [63:0] rsp_badaddr;

    int checks = 0;
    int errors = 0;
    logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;

    always #10 clk = ~clk;

    vaddr_seg_xlate uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_kind(req_kind), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
        .rsp_code(rsp_code), .rsp_paddr(rsp_paddr), .rsp_badaddr(rsp_badaddr)
    );

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] next_rand(input logic [63:0] s);
        logic [63:0] x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 7);
        x = x ^ (x << 17);
        return x;
    endfunction

    // Drive one request and check the response one cycle later.
    task automatic xlate(input logic [63:0] va, input logic [1:0] kind);
        logic [1:0]  top = va[63:62];
        logic        ok = 1'b0;
        logic [63:0] pa = '0;
        string       tag;
        if (top == 2'b10) begin
            ok = 1'b1; pa = va % (64'd1 << 59); tag = "R2";
        end else if (top == 2'b11) begin
            if (((va >> 31) % (64'd1 << 31)) != 64'h7FFF_FFFF) tag = "R5";
            else if (((va >> 29) % 4) >= 2) tag = "R4";
            else begin ok = 1'b1; pa = va % (64'd1 << 29); tag = "R3"; end
        end else tag = "R6";
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_kind = kind;
        @(negedge clk);
        req_valid = 1'b0;
        chk(rsp_valid == 1'b1, "R1 valid", {63'd0, rsp_valid}, 64'd1);
        chk(rsp_fault == !ok, tag, {63'd0, rsp_fault}, {63'd0, !ok});
        chk(rsp_paddr == pa, ok ? tag : "R8", rsp_paddr, pa);
        chk(rsp_code == (ok ? 5'd0 : (kind == 2'b10 ? 5'd5 : 5'd4)), "R7",
            {59'd0, rsp_code}, ok ? 64'd0 : (kind == 2'b10 ? 64'd5 : 64'd4));
        chk(rsp_badaddr == (ok ? 64'd0 : va), "R9", rsp_badaddr, ok ? 64'd0 : va);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // Reset with a request held high: outputs must stay cleared (R1).
        req_valid = 1'b1; req_vaddr = 64'h8000_0000_0000_1234;
        repeat (3) @(negedge clk);
        chk(rsp_valid == 1'b0 && rsp_paddr == 0, "R1 reset", rsp_paddr, 64'd0);
        req_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R1 idle", {63'd0, rsp_valid}, 64'd0);

        // Sweep regions, cache-mode bits and kinds (R2, R5, R6, R7).
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 8; c++)
                for (int k = 0; k < 4; k++) begin
                    seed = next_rand(seed);
                    xlate({r[1:0], c[2:0], seed[58:0]}, k[1:0]);
                end

        // Kernel compatibility view, all four segments (R3, R4).
        for (int s = 0; s < 4; s++)
            for (int k = 0; k < 4; k++)
                for (int n = 0; n < 3; n++) begin
                    seed = next_rand(seed);
                    xlate({2'b11, 31'h7FFF_FFFF, s[1:0], seed[28:0]}, k[1:0]);
                end

        // Clear one bit of the all-ones field at a time (R5).
        for (int b = 31; b < 62; b++)
            for (int k = 1; k < 3; k++) begin
                logic [63:0] va;
                seed = next_rand(seed);
                va = {2'b11, 31'h7FFF_FFFF, 2'b00, seed[28:0]};
                va[b] = 1'b0;
                xlate(va, k[1:0]);
            end

        // Idle cycle after traffic: response must drop (R1).
        @(negedge clk);
        chk(rsp_valid == 1'b0 && rsp_fault == 1'b0 && rsp_badaddr == 0, "R1 drop",
            rsp_badaddr, 64'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule